// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the control path that steers a small 32-bit processor into its exception handlers. It watches an active-low reset and two asynchronous interrupt request lines, a fast one and a normal one. When one of them wins, it produces the fetch redirection, the new status word and the write strobes that save the return address and the old status into the banked registers of the target mode. The core around it owns the register file and executes instructions. It reports instruction boundaries on a strobe, presents its current program counter and status word, and copies the status output into its own status register whenever the update strobe is high.

Each interrupt line passes through its own synchroniser chain. A synchronised request is taken only when its mask bit in the current status word is clear and the boundary strobe is high. The fast request wins any tie. Interrupt entry takes two cycles. In the first, the return address and old status go to the banked registers. In the second, fetch jumps to the vector and the new status word is issued. While reset is held low, the fetch address keeps advancing one word per cycle. After release, a single cycle puts the core in supervisor mode at address zero.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low, fetch_addr grows by 4 on every rising clock edge. The strobes redirect, psr_wr, lr_wr and spsr_wr stay low, psr_out reads 32'h0000_00D3 and bank_mode reads 5'b10011.
- R2: On the fourth rising edge after rst_n rises, lr_wr and spsr_wr pulse for one cycle with bank_mode = 5'b10011, lr_data = cur_pc and spsr_data = cur_psr. Neither strobe is high on the first three edges.
- R3: On that same edge, redirect and psr_wr pulse and fetch_addr becomes 0. psr_out equals cur_psr with bits [4:0] = 5'b10011, bit 7 (I) = 1, bit 6 (F) = 1 and bit 5 (T) = 0.
- R4: A request line driven high before rising edge 1 is synchronised through two flops. It can first be accepted on edge 3, and with the strobe high and the mask clear, redirect appears on edge 4.
- R5: A request is accepted only on an edge where insn_boundary is high. Until then it stays pending and nothing is written.
- R6: fiq_req is ignored while cur_psr bit 6 is 1, and irq_req is ignored while cur_psr bit 7 is 1.
- R7: Fast entry works as follows. On the accept edge, lr_wr and spsr_wr pulse with bank_mode = 5'b10001, lr_data = cur_pc and spsr_data = cur_psr. On the next edge, redirect and psr_wr pulse, fetch_addr = 32'h1C, and psr_out is the saved status with [4:0] = 5'b10001, I = 1, F = 1 and T = 0.
- R8: Normal entry follows the same two steps with bank_mode = 5'b10010 and fetch_addr = 32'h18. psr_out gets [4:0] = 5'b10010, I = 1 and T = 0, with F copied unchanged from the saved status.
- R9: When both requests are synchronised and unmasked on an accept edge, fast entry is taken. A normal request held through fast entry stays pending while I is set and is taken on the first boundary edge after I clears.
- R10: Every strobe is a one-cycle pulse. No entry starts in the cycle between the save step and the jump step, and after an entry no strobe fires unless a new request is accepted.
- R11: In normal running, fetch_addr equals the cur_pc value that was present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| fiq_req | input | 1 | Asynchronous fast interrupt request, active high |
| irq_req | input | 1 | Asynchronous normal interrupt request, active high |
| insn_boundary | input | 1 | High when the core may take an exception at this edge |
| cur_pc | input | ADDR_W | Return address offered by the core |
| cur_psr | input | 32 | Current status word of the core |
| fetch_addr | output | ADDR_W | Next fetch address |
| redirect | output | 1 | Pulse: fetch_addr is a vector |
| psr_out | output | 32 | Status word for the core to load |
| psr_wr | output | 1 | Pulse: load psr_out |
| bank_mode | output | 5 | Mode whose banked registers are written |
| lr_wr | output | 1 | Pulse: write lr_data to the banked link register |
| lr_data | output | ADDR_W | Saved return address |
| spsr_wr | output | 1 | Pulse: write spsr_data to the banked saved-status register |
| spsr_data | output | 32 | Saved status word |

## Verification
The bench sweeps the phase between a request and the boundary strobe and checks the exact accept edge. A sequencer that skipped a synchroniser stage, or that ignored the strobe, would jump one or more cycles early. Simultaneous requests catch a swapped priority, and a normal request held across fast entry catches a design that drops it or takes it while I is still set. Random mask patterns catch a mask test on the wrong bit. The check that F survives normal entry catches a status builder that always sets both mask bits. Counting fetch steps across a second, mid-run reset catches a counter that freezes or misses cycles in reset.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int PSR_W     = 32;
  localparam int PSR_T_BIT = 5;
  localparam int PSR_F_BIT = 6;
  localparam int PSR_I_BIT = 7;

  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;

  typedef logic [PSR_W-1:0] psr_t;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,  // held by reset, fetch keeps stepping
    ST_WAKE  = 2'd1,  // first free cycle, next edge enters supervisor
    ST_RUN   = 2'd2,  // normal running, interrupts may be accepted
    ST_SAVE  = 2'd3   // banked registers written, next edge jumps
  } seq_state_t;

  // Status word seen by the handler: new mode, I set, T cleared, F optional.
  function automatic psr_t psr_enter(input psr_t base, input logic [4:0] mode,
                                     input logic mask_fast);
    psr_t r;
    r            = base;
    r[4:0]       = mode;
    r[PSR_I_BIT] = 1'b1;
    if (mask_fast) r[PSR_F_BIT] = 1'b1;
    r[PSR_T_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/exc_req_sync.sv
module exc_req_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_async,
  output logic [LINES-1:0] req_sync
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], req_async[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= ff_d;
    end

    assign req_sync[g] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/exc_pick.sv
module exc_pick (
  input  logic fiq_pend,
  input  logic irq_pend,
  input  logic boundary,
  input  logic f_masked,
  input  logic i_masked,
  output logic take,
  output logic take_fast
);

  logic fiq_ok;
  logic irq_ok;

  always_comb begin
    fiq_ok    = fiq_pend & ~f_masked;
    irq_ok    = irq_pend & ~i_masked;
    take      = boundary & (fiq_ok | irq_ok);
    take_fast = fiq_ok;  // fast line wins any tie
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC   = '0,
  parameter logic [ADDR_W-1:0] IRQ_VEC     = ADDR_W'(32'h18),
  parameter logic [ADDR_W-1:0] FIQ_VEC     = ADDR_W'(32'h1C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_req,
  input  logic              irq_req,
  input  logic              insn_boundary,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [PSR_W-1:0]  cur_psr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              redirect,
  output logic [PSR_W-1:0]  psr_out,
  output logic              psr_wr,
  output logic [4:0]        bank_mode,
  output logic              lr_wr,
  output logic [ADDR_W-1:0] lr_data,
  output logic              spsr_wr,
  output logic [PSR_W-1:0]  spsr_data
);

  localparam int                REQ_LINES = 2;
  localparam int                LINE_FIQ  = 0;
  localparam int                LINE_IRQ  = 1;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam psr_t              RESET_PSR = psr_enter('0, MODE_SVC, 1'b1);

  // reset release and request synchronisers
  logic                 rst_sync_n;
  logic [REQ_LINES-1:0] req_async;
  logic [REQ_LINES-1:0] req_sync;
  logic                 take;
  logic                 take_fast;

  exc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign req_async[LINE_FIQ] = fiq_req;
  assign req_async[LINE_IRQ] = irq_req;

  exc_req_sync #(.LINES(REQ_LINES), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_async (req_async),
    .req_sync  (req_sync)
  );

  exc_pick u_pick (
    .fiq_pend  (req_sync[LINE_FIQ]),
    .irq_pend  (req_sync[LINE_IRQ]),
    .boundary  (insn_boundary),
    .f_masked  (cur_psr[PSR_F_BIT]),
    .i_masked  (cur_psr[PSR_I_BIT]),
    .take      (take),
    .take_fast (take_fast)
  );

  // state and output registers
  seq_state_t        state_q,   state_d;
  logic              kind_q,    kind_d;
  logic [ADDR_W-1:0] fetch_q,   fetch_d;
  psr_t              psr_q,     psr_d;
  logic              psr_wr_q,  psr_wr_d;
  logic              redir_q,   redir_d;
  logic              save_q,    save_d;
  logic [4:0]        bank_q,    bank_d;
  logic [ADDR_W-1:0] lr_q,      lr_d;
  psr_t              spsr_q,    spsr_d;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    fetch_d  = fetch_q;
    psr_d    = psr_q;
    psr_wr_d = 1'b0;
    redir_d  = 1'b0;
    save_d   = 1'b0;
    bank_d   = bank_q;
    lr_d     = lr_q;
    spsr_d   = spsr_q;
    unique case (state_q)
      ST_RESET: begin
        fetch_d = fetch_q + WORD_STEP;
        state_d = ST_WAKE;
      end
      ST_WAKE: begin
        state_d  = ST_RUN;
        kind_d   = 1'b0;
        fetch_d  = RESET_VEC;
        psr_d    = psr_enter(cur_psr, MODE_SVC, 1'b1);
        psr_wr_d = 1'b1;
        redir_d  = 1'b1;
        save_d   = 1'b1;
        bank_d   = MODE_SVC;
        lr_d     = cur_pc;
        spsr_d   = cur_psr;
      end
      ST_RUN: begin
        fetch_d = cur_pc;
        if (take) begin
          state_d = ST_SAVE;
          kind_d  = take_fast;
          save_d  = 1'b1;
          bank_d  = take_fast ? MODE_FIQ : MODE_IRQ;
          lr_d    = cur_pc;
          spsr_d  = cur_psr;
        end
      end
      ST_SAVE: begin
        state_d  = ST_RUN;
        fetch_d  = kind_q ? FIQ_VEC : IRQ_VEC;
        psr_d    = psr_enter(spsr_q, bank_q, kind_q);
        psr_wr_d = 1'b1;
        redir_d  = 1'b1;
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_RESET;
      kind_q   <= 1'b0;
      psr_q    <= RESET_PSR;
      psr_wr_q <= 1'b0;
      redir_q  <= 1'b0;
      save_q   <= 1'b0;
      bank_q   <= MODE_SVC;
      lr_q     <= '0;
      spsr_q   <= '0;
    end else begin
      state_q  <= state_d;
      psr_wr_q <= psr_wr_d;
      redir_q  <= redir_d;
      save_q   <= save_d;
      if (save_d) begin
        kind_q <= kind_d;
        bank_q <= bank_d;
        lr_q   <= lr_d;
        spsr_q <= spsr_d;
      end
      if (psr_wr_d) psr_q <= psr_d;
    end
  end

  // fetch counter keeps running through reset, so it carries no reset
  always_ff @(posedge clk) begin
    fetch_q <= fetch_d;
  end

  assign fetch_addr = fetch_q;
  assign redirect   = redir_q;
  assign psr_out    = psr_q;
  assign psr_wr     = psr_wr_q;
  assign bank_mode  = bank_q;
  assign lr_wr      = save_q;
  assign lr_data    = lr_q;
  assign spsr_wr    = save_q;
  assign spsr_data  = spsr_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = ADDR_W'(32'h18),
  parameter logic [ADDR_W-1:0] FIQ_VEC   = ADDR_W'(32'h1C)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_boundary,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              redirect,
  input logic [7:0]        psr_lo,
  input logic              psr_wr,
  input logic [4:0]        bank_mode,
  input logic              lr_wr,
  input logic              spsr_wr,
  input logic [7:0]        spsr_lo
);

  AST_SAVE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) // R2
    lr_wr == spsr_wr);

  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) // R3
    (lr_wr && bank_mode == MODE_SVC) |-> (redirect && psr_wr && fetch_addr == RESET_VEC
      && psr_lo[4:0] == MODE_SVC && psr_lo[PSR_I_BIT] && psr_lo[PSR_F_BIT] && !psr_lo[PSR_T_BIT]));

  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (lr_wr && bank_mode != MODE_SVC) |-> $past(insn_boundary));

  AST_FIQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (lr_wr && bank_mode == MODE_FIQ) |-> !spsr_lo[PSR_F_BIT]);

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (lr_wr && bank_mode == MODE_IRQ) |-> !spsr_lo[PSR_I_BIT]);

  AST_SAVE_THEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (lr_wr && bank_mode != MODE_SVC) |=> (redirect && psr_wr && psr_lo[4:0] == $past(bank_mode)));

  AST_FIQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (redirect && psr_lo[4:0] == MODE_FIQ) |-> (fetch_addr == FIQ_VEC
      && psr_lo[PSR_I_BIT] && psr_lo[PSR_F_BIT] && !psr_lo[PSR_T_BIT]));

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) // R8
    (redirect && psr_lo[4:0] == MODE_IRQ) |-> (fetch_addr == IRQ_VEC
      && psr_lo[PSR_I_BIT] && !psr_lo[PSR_T_BIT] && psr_lo[PSR_F_BIT] == spsr_lo[PSR_F_BIT]));

  AST_ONE_CYCLE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) // R10
    redirect |=> !redirect);

  AST_NO_SAVE_IN_JUMP: assert property (@(posedge clk) disable iff (!rst_n) // R10
    lr_wr |=> !lr_wr);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC),
  .IRQ_VEC   (IRQ_VEC),
  .FIQ_VEC   (FIQ_VEC)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .fetch_addr    (fetch_addr),
  .redirect      (redirect),
  .psr_lo        (psr_out[7:0]),
  .psr_wr        (psr_wr),
  .bank_mode     (bank_mode),
  .lr_wr         (lr_wr),
  .spsr_wr       (spsr_wr),
  .spsr_lo       (spsr_data[7:0])
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;

  logic        clk;
  logic        rst_n;
  logic        fiq_req;
  logic        irq_req;
  logic        insn_boundary;
  logic [31:0] cur_pc;
  logic [31:0] cur_psr;
  logic [31:0] fetch_addr;
  logic        redirect;
  logic [31:0] psr_out;
  logic        psr_wr;
  logic [4:0]  bank_mode;
  logic        lr_wr;
  logic [31:0] lr_data;
  logic        spsr_wr;
  logic [31:0] spsr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exc_entry_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fiq_req       (fiq_req),
    .irq_req       (irq_req),
    .insn_boundary (insn_boundary),
    .cur_pc        (cur_pc),
    .cur_psr       (cur_psr),
    .fetch_addr    (fetch_addr),
    .redirect      (redirect),
    .psr_out       (psr_out),
    .psr_wr        (psr_wr),
    .bank_mode     (bank_mode),
    .lr_wr         (lr_wr),
    .lr_data       (lr_data),
    .spsr_wr       (spsr_wr),
    .spsr_data     (spsr_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [31:0] want_psr(input logic [31:0] old, input logic [4:0] mode,
                                           input bit fast);
    logic [31:0] r;
    r      = old;
    r[4:0] = mode;
    r[7]   = 1'b1;
    r[6]   = fast ? 1'b1 : old[6];
    r[5]   = 1'b0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] strobes();
    return {28'd0, redirect, psr_wr, lr_wr, spsr_wr};
  endfunction

  // release reset and follow the supervisor entry (R2, R3)
  task automatic release_reset();
    logic [31:0] prev;
    rst_n = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      prev = fetch_addr;
      tick();
      check("R2 no save before fourth edge", strobes(), 32'd0);
      check("R1 step during release", fetch_addr, prev + 32'd4);
    end
    tick();
    check("R2 save strobes", strobes(), 32'hF);
    check("R2 bank", {27'd0, bank_mode}, {27'd0, M_SVC});
    check("R2 lr_data", lr_data, cur_pc);
    check("R2 spsr_data", spsr_data, cur_psr);
    check("R3 fetch zero", fetch_addr, 32'd0);
    check("R3 psr", psr_out, want_psr(cur_psr, M_SVC, 1'b1));
    cur_psr = psr_out;
    tick();
    check("R10 strobes drop", strobes(), 32'd0);
    check("R11 fetch follows pc", fetch_addr, cur_pc);
  endtask

  // d = edge index minus one at which the strobe rises; d < 0 means never
  task automatic run_trial(input bit f, input bit i, input logic [31:0] psr, input int d);
    bit          fok, iok, expect_entry;
    int          e, last;
    logic [31:0] pc;
    logic [4:0]  m;
    pc            = $urandom() & 32'hFFFF_FFFC;
    cur_pc        = pc;
    cur_psr       = psr;
    insn_boundary = 1'b0;
    fiq_req       = f;
    irq_req       = i;
    fok           = f && !psr[6];
    iok           = i && !psr[7];
    expect_entry  = (fok || iok) && (d >= 0);
    e             = (d + 1 > 3) ? d + 1 : 3;
    last          = expect_entry ? e + 1 : 8;
    m             = fok ? M_FIQ : M_IRQ;
    for (int n = 1; n <= last; n++) begin
      if (d >= 0 && n == d + 1) insn_boundary = 1'b1;
      tick();
      if (!expect_entry) begin
        check((fok || iok) ? "R5 held without boundary" : "R6 masked request ignored",
              strobes(), 32'd0);
      end else if (n < e) begin
        check((n < d + 1) ? "R5 wait for boundary" : "R4 synchroniser delay", strobes(), 32'd0);
      end else if (n == e) begin
        check(fok ? "R7 save strobes" : "R8 save strobes", strobes(), 32'h3);
        check((f && i && fok) ? "R9 fast wins" : "R7 R8 bank", {27'd0, bank_mode}, {27'd0, m});
        check("R7 lr_data", lr_data, pc);
        check("R7 spsr_data", spsr_data, psr);
      end else begin
        check("R4 jump strobes", strobes(), 32'hC);
        check(fok ? "R7 vector" : "R8 vector", fetch_addr, fok ? 32'h1C : 32'h18);
        check(fok ? "R7 psr" : "R8 psr", psr_out, want_psr(psr, m, fok));
      end
    end
    fiq_req       = 1'b0;
    irq_req       = 1'b0;
    insn_boundary = 1'b0;
    if (expect_entry) cur_psr = psr_out;
    for (int n = 0; n < 4; n++) begin
      tick();
      check("R10 quiet after entry", strobes(), 32'd0);
    end
  endtask

  initial begin
    logic [31:0] prev;
    logic [31:0] saved;
    void'($urandom(32'd4242));
    rst_n         = 1'b0;
    fiq_req       = 1'b0;
    irq_req       = 1'b0;
    insn_boundary = 1'b0;
    cur_pc        = 32'h0000_1000;
    cur_psr       = 32'h0000_0010;
    @(negedge clk);
    tick();
    check("R1 reset strobes", strobes(), 32'd0);
    check("R1 reset psr", psr_out, 32'h0000_00D3);
    check("R1 reset bank", {27'd0, bank_mode}, {27'd0, M_SVC});
    for (int n = 0; n < 3; n++) begin
      prev = fetch_addr;
      tick();
      check("R1 fetch steps", fetch_addr, prev + 32'd4);
    end
    release_reset();

    // R11: fetch follows a new pc one edge later
    cur_pc = 32'h0000_4A00;
    tick();
    check("R11 fetch follows pc", fetch_addr, 32'h0000_4A00);

    // R1: reset in the middle of running, stepping from a known address
    rst_n = 1'b0;
    for (int n = 1; n <= 3; n++) begin
      tick();
      check("R1 step from known pc", fetch_addr, 32'h0000_4A00 + 32'(4 * n));
      check("R1 strobes low in reset", strobes(), 32'd0);
    end
    cur_pc  = 32'h0000_8000;
    cur_psr = 32'hF000_0030;
    release_reset();
    cur_psr = 32'h0000_0010;

    // directed corners
    run_trial(1'b1, 1'b0, 32'h0000_0010, 0);   // R4 minimum latency
    run_trial(1'b0, 1'b1, 32'h0000_0050, 0);   // R8 with F kept set
    run_trial(1'b1, 1'b1, 32'h0000_0030, 2);   // R9 same-cycle tie
    run_trial(1'b1, 1'b0, 32'h0000_0010, -1);  // R5 no boundary
    run_trial(1'b1, 1'b1, 32'h0000_00D0, 0);   // R6 both masked
    run_trial(1'b0, 1'b1, 32'h0000_0030, 6);   // R5 late boundary

    // R9: normal request held through fast entry
    cur_pc        = 32'h0000_2220;
    cur_psr       = 32'h0000_0010;
    fiq_req       = 1'b1;
    irq_req       = 1'b1;
    insn_boundary = 1'b1;
    repeat (3) tick();
    check("R9 fast taken first", {27'd0, bank_mode}, {27'd0, M_FIQ});
    tick();
    check("R9 fast vector", fetch_addr, 32'h1C);
    fiq_req = 1'b0;
    cur_psr = psr_out;
    cur_pc  = 32'h0000_0040;
    for (int n = 0; n < 5; n++) begin
      tick();
      check("R9 normal held while I set", strobes(), 32'd0);
    end
    cur_psr[7] = 1'b0;
    saved      = cur_psr;
    tick();
    check("R9 pending normal taken", {27'd0, bank_mode}, {27'd0, M_IRQ});
    check("R9 saved status", spsr_data, saved);
    tick();
    check("R8 vector after hold", fetch_addr, 32'h18);
    check("R8 F unchanged", psr_out, want_psr(saved, M_IRQ, 1'b0));
    irq_req       = 1'b0;
    insn_boundary = 1'b0;
    cur_psr       = 32'h0000_0010;
    repeat (4) tick();

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [31:0] p;
      p = ($urandom() & 32'hFFFF_FF20) | 32'h10 | (($urandom() % 4) << 6);
      run_trial(1'($urandom()), 1'($urandom()), p, int'($urandom() % 6));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule